// File: doc/BRIEF.md
# Cost-Weighted Victim Selector

This block is the replacement engine for one set of a sixteen-way cache. Each way holds a valid flag, a position in the recency stack and a three-bit code for the miss cost that was measured when its line was brought in. On every cycle the block names the way to evict. An empty way is always chosen first. Once the set is full, the block picks the way with the lowest sum of recency position and the programmable weight times the stored cost code.

The surrounding cache controller reports each hit and each fill, giving the way and, for a fill, the cost code. The block moves that way to the most recently used position and closes the gap it leaves. The victim output depends only on the current state and the weight input, with no register in between. A controller can therefore read it in the same cycle it issues a fill and use it as the fill way. Setting the weight to zero turns the selector into plain LRU.

Top module: `cost_victim_sel`

## Requirements
- R1: After reset every way is invalid and `victim_way` is 0.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way, whatever the scores are.
- R3: When all ways are valid, `victim_way` is a way with the smallest score. The score is the way's recency position (0 = least recently used, 15 = most recently used) plus `weight_s` times its stored cost code.
- R4: When several valid ways share the smallest score, the lowest-numbered of them is chosen.
- R5: With `weight_s` = 0 and all ways valid, `victim_way` is the least recently used way.
- R6: An access (`acc_valid` = 1, either kind) moves `acc_way` to recency 15. Every way whose position was above the old position of `acc_way` drops by one, and the others keep their position. The new order is visible in the cycle after the clock edge.
- R7: A fill (`acc_kind` = 1) marks `acc_way` valid and stores `fill_cost` as its cost code. A hit (`acc_kind` = 0) leaves every cost code unchanged.
- R8: `victim_way` follows a change of `weight_s` within the same cycle, without a clock edge.
- R9: The sixteen recency positions always form a permutation of 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_kind | input | 1 | 0 = hit, 1 = fill |
| acc_way | input | 4 | Way accessed |
| fill_cost | input | 3 | Quantized miss cost stored on a fill |
| weight_s | input | 3 | Weight of the cost term in the score |
| victim_way | output | 4 | Way to evict next |

## Verification
The assertions assume that a hit is reported only for a valid way and that `acc_way` is always a legal way number. Invalid ways carry stale recency and cost values that mean nothing. The stimulus follows this rule: it fills every way before it reports any hit, and it only reports hits to ways it has already filled. The weight may change at any cycle, because the block places no limit on it.

// File: rtl/cvs_pkg.sv
// Package: shared encodings for the cost-weighted victim selector.
// Assumes: one access kind bit, 0 for hit, 1 for fill.
package cvs_pkg;
    typedef enum logic {
        ACC_HIT  = 1'b0,
        ACC_FILL = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/cvs_state.sv
// Module: cvs_state
// Holds per-way valid, recency position and cost code for one set, and
// updates them on a hit or fill. Assumes hits name only valid ways.
module cvs_state #(
    parameter int WAYS   = 16,
    parameter int COST_W = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid,
    input  logic                         acc_kind,
    input  logic [WAY_W-1:0]             acc_way,
    input  logic [COST_W-1:0]            fill_cost,
    output logic [WAYS-1:0]              way_valid,
    output logic [WAYS-1:0][WAY_W-1:0]   way_rec,
    output logic [WAYS-1:0][COST_W-1:0]  way_cost
);
    import cvs_pkg::*;

    localparam logic [WAY_W-1:0] MRU_POS = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] old_pos;

    // Purpose: fetch the current stack position of the accessed way.
    always_comb begin
        old_pos = way_rec[acc_way];
    end

    // Purpose: recency stack update, accessed way to MRU, gap closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) way_rec[i] <= WAY_W'(i);
        end else if (acc_valid) begin
            for (int i = 0; i < WAYS; i++) begin
                if (WAY_W'(i) == acc_way)  way_rec[i] <= MRU_POS;
                else if (way_rec[i] > old_pos) way_rec[i] <= way_rec[i] - 1'b1;
            end
        end
    end

    // Purpose: valid flag and cost code capture on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_valid <= '0;
            way_cost  <= '0;
        end else if (acc_valid && acc_kind == ACC_FILL) begin
            way_valid[acc_way] <= 1'b1;
            way_cost[acc_way]  <= fill_cost;
        end
    end

    // Assertion support: which stack positions are occupied.
    logic [WAYS-1:0] pos_used;
    always_comb begin
        pos_used = '0;
        for (int i = 0; i < WAYS; i++) pos_used[way_rec[i]] = 1'b1;
    end

    p_stack_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos_used) == WAYS);

    p_mru_after_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> way_rec[$past(acc_way)] == MRU_POS);

    p_fill_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == ACC_FILL) |=>
            (way_cost[$past(acc_way)] == $past(fill_cost)) && way_valid[$past(acc_way)]);

    p_hit_keeps_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == ACC_HIT) |=> $stable(way_cost));
endmodule

// File: rtl/cvs_scorer.sv
// Module: cvs_scorer
// Forms each way's score, recency plus weight times cost code, one
// generated lane per way. Pure combinational.
module cvs_scorer #(
    parameter int WAYS   = 16,
    parameter int COST_W = 3,
    parameter int S_W    = 3,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int SCORE_W = WAY_W + COST_W + S_W
) (
    input  logic [WAYS-1:0][WAY_W-1:0]    way_rec,
    input  logic [WAYS-1:0][COST_W-1:0]   way_cost,
    input  logic [S_W-1:0]                weight_s,
    output logic [WAYS-1:0][SCORE_W-1:0]  way_score
);
    for (genvar g = 0; g < WAYS; g++) begin : g_lane
        // Purpose: weighted score of lane g.
        always_comb begin
            way_score[g] = SCORE_W'(way_rec[g])
                         + SCORE_W'(weight_s) * SCORE_W'(way_cost[g]);
        end
    end
endmodule

// File: rtl/cvs_pick.sv
// Module: cvs_pick
// Picks the lowest invalid way if any; otherwise the lowest-index way
// with the minimum score. Pure combinational scan.
module cvs_pick #(
    parameter int WAYS    = 16,
    parameter int SCORE_W = 10,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]               way_valid,
    input  logic [WAYS-1:0][SCORE_W-1:0]  way_score,
    output logic [WAY_W-1:0]              pick_way
);
    logic [WAY_W-1:0]   inv_way;
    logic               inv_any;
    logic [WAY_W-1:0]   min_way;
    logic [SCORE_W-1:0] min_score;

    // Purpose: lowest-numbered invalid way.
    always_comb begin
        inv_any = 1'b0;
        inv_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) begin
                inv_any = 1'b1;
                inv_way = WAY_W'(i);
            end
        end
    end

    // Purpose: minimum score scan, strict compare keeps the lower index on ties.
    always_comb begin
        min_way   = '0;
        min_score = way_score[0];
        for (int i = 1; i < WAYS; i++) begin
            if (way_score[i] < min_score) begin
                min_score = way_score[i];
                min_way   = WAY_W'(i);
            end
        end
    end

    // Purpose: invalid ways take precedence over any score.
    always_comb begin
        pick_way = inv_any ? inv_way : min_way;
    end
endmodule

// File: rtl/cost_victim_sel.sv
// Module: cost_victim_sel
// Replacement engine for one set: tracks recency and cost per way and
// outputs the victim combinationally. Assumes hits target valid ways.
module cost_victim_sel #(
    parameter int WAYS   = 16,
    parameter int COST_W = 3,
    parameter int S_W    = 3,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int SCORE_W = WAY_W + COST_W + S_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_kind,
    input  logic [WAY_W-1:0]   acc_way,
    input  logic [COST_W-1:0]  fill_cost,
    input  logic [S_W-1:0]     weight_s,
    output logic [WAY_W-1:0]   victim_way
);
    logic [WAYS-1:0]              way_valid;
    logic [WAYS-1:0][WAY_W-1:0]   way_rec;
    logic [WAYS-1:0][COST_W-1:0]  way_cost;
    logic [WAYS-1:0][SCORE_W-1:0] way_score;

    cvs_state #(.WAYS(WAYS), .COST_W(COST_W)) u_state (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_way(acc_way), .fill_cost(fill_cost), .way_valid(way_valid),
        .way_rec(way_rec), .way_cost(way_cost)
    );

    cvs_scorer #(.WAYS(WAYS), .COST_W(COST_W), .S_W(S_W)) u_scorer (
        .way_rec(way_rec), .way_cost(way_cost), .weight_s(weight_s),
        .way_score(way_score)
    );

    cvs_pick #(.WAYS(WAYS), .SCORE_W(SCORE_W)) u_pick (
        .way_valid(way_valid), .way_score(way_score), .pick_way(victim_way)
    );

    // Assertion support: does some valid way beat or tie-and-precede the victim?
    logic better_seen;
    always_comb begin
        better_seen = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (way_score[i] < way_score[victim_way]) better_seen = 1'b1;
            if (way_score[i] == way_score[victim_way] && WAY_W'(i) < victim_way)
                better_seen = 1'b1;
        end
    end

    p_invalid_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&way_valid) |-> !way_valid[victim_way]);

    p_min_score_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&way_valid) |-> !better_seen);

    p_lru_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&way_valid) && weight_s == '0) |-> way_rec[victim_way] == '0);

    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (way_valid == '0));
endmodule

// File: tb/cost_victim_sel_bench.sv
module cost_victim_sel_bench;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_kind = 1'b0;
    logic [3:0] acc_way = '0;
    logic [2:0] fill_cost = '0;
    logic [2:0] weight_s = '0;
    logic [3:0] victim_way;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_rec[16];
    int m_cost[16];
    bit m_val[16];

    always #(CLK_NS/2) clk = ~clk;

    cost_victim_sel u_cost_victim_sel (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_way(acc_way), .fill_cost(fill_cost), .weight_s(weight_s),
        .victim_way(victim_way)
    );

    function automatic int model_victim();
        int best = 0;
        int best_sc = 1000;
        for (int i = 0; i < 16; i++) if (!m_val[i]) return i;
        for (int i = 0; i < 16; i++) begin
            int sc = m_rec[i] + int'(weight_s) * m_cost[i];
            if (sc < best_sc) begin best_sc = sc; best = i; end
        end
        return best;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_access(bit fill, int w, int c);
        int p = m_rec[w];
        for (int i = 0; i < 16; i++)
            if (i != w && m_rec[i] > p) m_rec[i]--;
        m_rec[w] = 15;
        if (fill) begin m_val[w] = 1'b1; m_cost[w] = c; end
    endtask

    // Drive one access at a falling edge; results checked at the next falling edge.
    task automatic access(bit fill, int w, int c);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = fill; acc_way = 4'(w); fill_cost = 3'(c);
        @(negedge clk);
        acc_valid = 1'b0;
        model_access(fill, w, c);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin m_rec[i] = i; m_cost[i] = 0; m_val[i] = 0; end
        #1;
    endtask

    task automatic t_reset_r1();
        weight_s = 3'd3;
        do_reset();
        check("R1 reset victim", victim_way, 0);
    endtask

    task automatic t_invalid_first_r2();
        do_reset();
        weight_s = 3'd7;
        access(1, 3, 0);
        check("R2 lowest invalid", victim_way, 0);
        access(1, 0, 7);
        check("R2 lowest invalid", victim_way, 1);
        access(1, 1, 7);
        access(1, 2, 7);
        check("R2 skip filled", victim_way, 4);
        for (int w = 4; w < 15; w++) access(1, w, 7);
        check("R2 last invalid", victim_way, 15);
    endtask

    task automatic t_lru_r5();
        do_reset();
        weight_s = 3'd0;
        for (int w = 0; w < 16; w++) access(1, w, (w * 3) % 8);
        check("R5 lru after fills", victim_way, 0);
        access(0, 0, 0);
        check("R5 lru after hit", victim_way, 1);
        access(0, 1, 0);
        access(0, 2, 0);
        check("R5 lru after hits", victim_way, 3);
        check("R5 model", victim_way, model_victim());
    endtask

    task automatic t_weighted_r3();
        do_reset();
        weight_s = 3'd0;
        for (int w = 0; w < 16; w++) access(1, w, (w * 5 + 3) % 8);
        for (int s = 1; s < 8; s += 2) begin
            @(negedge clk); weight_s = 3'(s); #1;
            check("R3 weighted min", victim_way, model_victim());
        end
        weight_s = 3'd2;
        access(0, 9, 0);
        check("R3 after hit, R7 cost kept", victim_way, model_victim());
        access(1, 4, 0);
        check("R7 refill stores cost", victim_way, model_victim());
        access(0, 12, 0);
        access(0, 6, 0);
        check("R6 reorder", victim_way, model_victim());
    endtask

    task automatic t_tie_r4();
        do_reset();
        weight_s = 3'd1;
        access(1, 0, 1);
        for (int w = 1; w < 16; w++) access(1, w, 0);
        check("R4 tie lowest index", victim_way, 0);
        access(0, 0, 0);
        check("R6 gap closed", victim_way, 1);
    endtask

    task automatic t_comb_r8();
        do_reset();
        weight_s = 3'd0;
        access(1, 0, 7);
        for (int w = 1; w < 16; w++) access(1, w, 0);
        check("R8 s=0 victim", victim_way, 0);
        #3 weight_s = 3'd1;
        #1;
        check("R8 same-cycle follow", victim_way, 1);
        check("R8 model", victim_way, model_victim());
    endtask

    initial begin
        t_reset_r1();
        t_invalid_first_r2();
        t_lru_r5();
        t_weighted_r3();
        t_tie_r4();
        t_comb_r8();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule